// File: doc/BRIEF.md
# Privilege-Gated Address Window Guard with Countdown Timer

This block sits beside a processor's memory port and decides, access by access, whether an address may be used. It keeps a single privilege bit. Value 0 is the privileged supervisor state and value 1 is the unprivileged application state. It also keeps a window start register, a window size register and a countdown timer. While the privilege bit is 0, every address is granted. While it is 1, only addresses inside the window are granted. An access outside the window, or any attempt to write the guard's registers, raises a one-cycle fault and drops the core back to the supervisor state.

Software in the supervisor state programs the guard through one write port. A two-bit select picks the target: 0 is the window start, 1 is the window size, 2 is the timer, and 3 is the command that enters the application state. The timer lets supervisor code take control back from a program that never yields. Once loaded, the timer counts down on every clock. When it reaches zero it pulses an interrupt and forces the supervisor state.

Top module: `mem_guard`

## Requirements
- R1: After reset, user_mode, prot_fault and timer_irq are 0, the window start and window size are 0, and the timer is 0, which means it is disabled.
- R2: While user_mode is 0, acc_grant equals acc_valid for every address, in the same cycle.
- R3: While user_mode is 1, acc_grant is 1 exactly when acc_valid is 1 and start <= acc_addr < start + size. The sum is formed one bit wider than the address, so a window that runs past the top of the address space does not wrap around to low addresses. A size of 0 grants nothing.
- R4: A valid access in user mode that falls outside the window makes prot_fault 1 for one cycle after the access edge. user_mode becomes 0 at that same edge.
- R5: A write with wr_en=1 while user_mode is 0 and wr_sel=0 loads the window start from wr_data, and wr_sel=1 loads the window size. The new value governs checks from the next cycle on.
- R6: Any write with wr_en=1 while user_mode is 1 changes no register and does not enter user mode. It pulses prot_fault at the next edge and sets user_mode to 0.
- R7: A write with wr_sel=3 while user_mode is 0 sets user_mode to 1 at the next edge. No other event sets it.
- R8: A write with wr_sel=2 while user_mode is 0 loads the timer with the low TW bits of wr_data. A loaded value N>0 makes timer_irq a one-cycle pulse N edges after the load edge, and user_mode becomes 0 at that edge. Reloading the timer before it expires restarts the count.
- R9: A timer value of 0 never raises timer_irq. After the pulse the count stays at 0 and does not fire again unless the timer is reloaded.
- R10: When the timer expires at the same edge as a wr_sel=3 command, user_mode stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Memory access request present |
| acc_addr | input | AW | Address of the request |
| acc_grant | output | 1 | Request is allowed (combinational) |
| wr_en | input | 1 | Register write or command request |
| wr_sel | input | 2 | 0 start, 1 size, 2 timer, 3 enter user mode |
| wr_data | input | AW | Write value |
| user_mode | output | 1 | Privilege bit: 0 supervisor, 1 user |
| prot_fault | output | 1 | One-cycle protection fault pulse |
| timer_irq | output | 1 | One-cycle timer expiry pulse |

## Verification
Several properties are checked on every cycle. Supervisor accesses are always granted. A user access that is refused, or a register write issued from user mode, is followed by a fault and a return to the supervisor state. The window registers do not change while the core is in user mode. An interrupt is never seen in user mode, and user mode is entered only through the command write. The exact window edges, the wide-sum behaviour near the top of the address space, and the timing and uniqueness of the timer pulse can only be shown by the bench's scenarios. These scenarios compare each grant, fault and pulse against a reference model, across random traffic and directed edge cases.

// File: rtl/mem_guard.sv
module mem_guard #(
  parameter int AW = 16,
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  output logic          acc_grant,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  output logic          user_mode,
  output logic          prot_fault,
  output logic          timer_irq
);
  localparam logic [1:0] SEL_START = 2'd0;
  localparam logic [1:0] SEL_SIZE  = 2'd1;
  localparam logic [1:0] SEL_TIMER = 2'd2;
  localparam logic [1:0] SEL_USER  = 2'd3;
  localparam logic [TW-1:0] T_ONE  = TW'(1);

  logic [AW-1:0] base_q, limit_q;
  logic [TW-1:0] timer_q;
  logic [AW:0]   win_end;
  logic          in_win, priv_wr, violation, ld_timer, expire;

  assign win_end   = {1'b0, base_q} + {1'b0, limit_q};
  assign in_win    = (acc_addr >= base_q) && ({1'b0, acc_addr} < win_end);
  assign acc_grant = acc_valid && (!user_mode || in_win);
  assign priv_wr   = wr_en && !user_mode;
  assign violation = (acc_valid && user_mode && !in_win) || (wr_en && user_mode);
  assign ld_timer  = priv_wr && (wr_sel == SEL_TIMER);
  assign expire    = !ld_timer && (timer_q == T_ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q     <= '0;
      limit_q    <= '0;
      timer_q    <= '0;
      user_mode  <= 1'b0;
      prot_fault <= 1'b0;
      timer_irq  <= 1'b0;
    end else begin
      prot_fault <= violation;
      timer_irq  <= expire;
      if (priv_wr && wr_sel == SEL_START) base_q  <= wr_data;
      if (priv_wr && wr_sel == SEL_SIZE)  limit_q <= wr_data;
      if (ld_timer)              timer_q <= wr_data[TW-1:0];
      else if (timer_q != '0)    timer_q <= timer_q - T_ONE;
      if (violation || expire)                  user_mode <= 1'b0;
      else if (priv_wr && wr_sel == SEL_USER)   user_mode <= 1'b1;
    end
  end
endmodule

module mem_guard_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_valid,
  input logic [AW-1:0] acc_addr,
  input logic          acc_grant,
  input logic          wr_en,
  input logic [1:0]    wr_sel,
  input logic          user_mode,
  input logic          prot_fault,
  input logic          timer_irq,
  input logic [AW-1:0] base_q,
  input logic [AW-1:0] limit_q
);
  p_monitor_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !user_mode) |-> acc_grant);

  p_grant_inside_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (user_mode && acc_grant) |-> (acc_addr >= base_q &&
      ({1'b0, acc_addr} < ({1'b0, base_q} + {1'b0, limit_q}))));

  p_refusal_faults_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && user_mode && !acc_grant) |=> (prot_fault && !user_mode));

  p_user_write_faults_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && user_mode) |=> (prot_fault && !user_mode));

  p_regs_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    user_mode |=> ($stable(base_q) && $stable(limit_q)));

  p_entry_by_command_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(user_mode) |-> $past(wr_en && wr_sel == 2'd3));

  p_irq_in_monitor_r8: assert property (@(posedge clk) disable iff (!rst_n)
    timer_irq |-> !user_mode);
endmodule

bind mem_guard mem_guard_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
  .acc_grant(acc_grant), .wr_en(wr_en), .wr_sel(wr_sel), .user_mode(user_mode),
  .prot_fault(prot_fault), .timer_irq(timer_irq), .base_q(base_q), .limit_q(limit_q)
);

// File: tb/mem_guard_tb_top.sv
`timescale 1ns/1ps
module mem_guard_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_valid = 1'b0, wr_en = 1'b0;
  logic [15:0] acc_addr = '0, wr_data = '0;
  logic [1:0] wr_sel = '0;
  logic acc_grant, user_mode, prot_fault, timer_irq;

  int checks = 0, fails = 0;
  logic m_user = 0, m_fresh = 0;
  logic [15:0] m_base = 0, m_limit = 0;
  logic [11:0] m_timer = 0;

  always #2.5 clk = ~clk;

  mem_guard dut_i (.clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_grant(acc_grant), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .user_mode(user_mode), .prot_fault(prot_fault), .timer_irq(timer_irq));

  function automatic logic inside_win(input logic [15:0] a);
    return (a >= m_base) && ({1'b0, a} < ({1'b0, m_base} + {1'b0, m_limit}));
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [15:0] a, input logic w,
                      input logic [1:0] s, input logic [15:0] d);
    logic bad_acc, bad_wr, pw, ld, e_irq, go, n_user;
    string tu;
    @(negedge clk);
    acc_valid = v; acc_addr = a; wr_en = w; wr_sel = s; wr_data = d;
    #1;
    chk(acc_grant, v && (!m_user || inside_win(a)),
        !m_user ? "R2" : (m_fresh ? "R5" : "R3"));
    if (m_user && v) m_fresh = 0;
    bad_acc = v && m_user && !inside_win(a);
    bad_wr  = w && m_user;
    pw      = w && !m_user;
    ld      = pw && s == 2'd2;
    e_irq   = !ld && m_timer == 12'd1;
    go      = pw && s == 2'd3;
    n_user  = (bad_acc || bad_wr || e_irq) ? 1'b0 : (go ? 1'b1 : m_user);
    tu = (go && e_irq) ? "R10" : go ? "R7" : bad_wr ? "R6" : e_irq ? "R8" : "R4";
    @(posedge clk); #1;
    chk(prot_fault, bad_acc || bad_wr, bad_wr ? "R6" : "R4");
    chk(timer_irq, e_irq, (m_timer == 0) ? "R9" : "R8");
    chk(user_mode, n_user, tu);
    if (pw && s == 2'd0) begin m_base = d; m_fresh = 1; end
    if (pw && s == 2'd1) begin m_limit = d; m_fresh = 1; end
    if (ld) m_timer = d[11:0];
    else if (m_timer != 0) m_timer = m_timer - 12'd1;
    m_user = n_user;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 16'h0, 0, 2'd0, 16'h0);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #750000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    #12 rst_n = 1'b1;
    #1;
    chk(user_mode, 0, "R1"); chk(prot_fault, 0, "R1"); chk(timer_irq, 0, "R1");
    idle(20);                                   // R1 / R9: timer disabled after reset
    step(1, 16'hBEEF, 0, 2'd0, 0);               // R2 monitor grants anything
    // R5 program window 0x1000..0x10FF, then R7 enter user
    step(0, 0, 1, 2'd0, 16'h1000);
    step(0, 0, 1, 2'd1, 16'h0100);
    step(0, 0, 1, 2'd3, 0);
    step(1, 16'h1000, 0, 0, 0);                  // R3 lower edge
    step(1, 16'h10FF, 0, 0, 0);                  // R3 upper edge
    step(1, 16'h1100, 0, 0, 0);                  // R4 just past end
    step(0, 0, 1, 2'd3, 0);                      // enter again
    step(1, 16'h0FFF, 0, 0, 0);                  // R4 just below start
    step(0, 0, 1, 2'd3, 0);
    step(0, 0, 1, 2'd0, 16'h0000);               // R6 user write faults
    step(1, 16'h1000, 0, 0, 0);                  // monitor again
    step(0, 0, 1, 2'd3, 0);
    step(1, 16'h1000, 0, 0, 0);                  // R6 start unchanged
    // R3 wide sum: window 0xFFF0 size 0x20 must not wrap
    step(0, 0, 1, 2'd0, 16'hFFF0);
    step(0, 0, 1, 2'd1, 16'h0020);
    step(0, 0, 1, 2'd3, 0);
    step(1, 16'hFFFF, 0, 0, 0);
    step(1, 16'h0005, 0, 0, 0);
    // R3 zero size grants nothing
    step(0, 0, 1, 2'd1, 16'h0000);
    step(0, 0, 1, 2'd3, 0);
    step(1, 16'hFFF0, 0, 0, 0);
    // R8 timer of 5 in user mode, R9 no retrigger
    step(0, 0, 1, 2'd1, 16'h0010);
    step(0, 0, 1, 2'd2, 16'h0005);
    step(0, 0, 1, 2'd3, 0);
    idle(12);
    // R8 reload restarts
    step(0, 0, 1, 2'd2, 16'h0003);
    step(0, 0, 1, 2'd2, 16'h0004);
    idle(8);
    // R10 expiry coincides with entry command
    step(0, 0, 1, 2'd2, 16'h0001);
    step(0, 0, 1, 2'd3, 0);
    idle(3);
    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      logic v, w; logic [1:0] s; logic [15:0] a, d; int r;
      r = $urandom % 100;
      w = (r < 10) || (!m_user && r < 25);
      s = (!m_user && r >= 10 && r < 25) ? 2'd3 : 2'($urandom % 4);
      case (s)
        2'd0: d = 16'($urandom);
        2'd1: d = ($urandom % 4 == 0) ? 16'($urandom) : 16'($urandom % 512);
        2'd2: d = 16'($urandom % 40);
        default: d = 16'($urandom);
      endcase
      v = ($urandom % 100) < 75;
      case ($urandom % 3)
        0: a = 16'($urandom);
        1: a = m_base + m_limit + 16'($urandom % 5) - 16'd2;
        default: a = m_base + 16'($urandom % 3) - 16'd1;
      endcase
      step(v, a, w, s, d);
    end
    finish_run();
  end
endmodule